// File: doc/BRIEF.md
# Shadow-Stack Enable Control Unit

This unit holds the three environment-configuration registers (machine, hypervisor and supervisor level) that carry a shadow-stack enable flag, together with the shadow-stack-pointer register. From the stored flags, the current privilege mode and the virtualization flag, it derives the effective shadow-stack enable for the running code.

It also guards the shadow-stack-pointer register against accesses that are not allowed. It tells the instruction decoder when shadow-stack opcodes must fall back to may-be-operation behaviour. It marks first-stage leaf page-table permission codes that are reserved while the feature is switched off at machine level.

CSR requests are single-cycle. Read data, the effective enable and all flags are combinational. Writes land on the next rising clock edge. Instruction execution and page walking are done by other blocks.

Top module: `sstk_enable_ctl`

## Requirements
- R1: After reset the three configuration registers and the shadow-stack pointer read as zero.
- R2: With `priv` = 2'b11 (machine mode), `eff_en` is 1 whatever the stored flags are.
- R3: The enable flag is bit 3 of each configuration register. `eff_en` selects it per mode: with `priv` = 2'b01 and `virt` = 0 it follows the machine-level flag; with `priv` = 2'b01 and `virt` = 1 it follows the hypervisor-level flag; with `priv` = 2'b00 it follows the supervisor-level flag for either value of `virt`.
- R4: While the machine-level flag is 0, bit 3 of the hypervisor-level and supervisor-level registers reads 0, and a write of 1 to that bit is dropped.
- R5: Writing 0 to the machine-level flag clears the stored lower-level flags on the same edge. Setting it to 1 again leaves them at 0.
- R6: A write takes effect on the next rising edge. Only bytes whose `csr_wstrb` bit is 1 change, and every bit other than the lower-level flags is stored exactly as written.
- R7: A shadow-stack-pointer access from below machine mode while `eff_en` is 0 raises `illegal`. Such a write is dropped and such a read returns 0.
- R8: From machine mode, or while `eff_en` is 1, the shadow-stack pointer is a full-width read/write register, and `illegal` stays 0.
- R9: `mop_fallback` is 1 exactly when `priv` is not 2'b11 and the machine-level flag is 0.
- R10: `pte_rsvd` is 1 exactly when the machine-level flag is 0 and `pte_perm` = 3'b010. In `pte_perm`, bit 2 is read, bit 1 is write and bit 0 is execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_req | input | 1 | CSR access request this cycle |
| csr_we | input | 1 | Request is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_wstrb | input | XLEN/8 | Byte write enables |
| priv | input | 2 | Current mode: 3 machine, 1 supervisor, 0 user |
| virt | input | 1 | Virtualized execution |
| pte_perm | input | 3 | Leaf permission field {R,W,X} to classify |
| csr_rdata | output | XLEN | Read data, 0 when no register is hit or the access is illegal |
| eff_en | output | 1 | Effective shadow-stack enable for the current mode |
| illegal | output | 1 | Illegal-instruction indication for this request |
| pte_rsvd | output | 1 | Permission field is a reserved encoding |
| mop_fallback | output | 1 | Decoder treats shadow-stack opcodes as may-be-operations |

## Verification
The assertions take `priv` to be one of the three defined encodings and take a request to hit at most one register. The encoding 2'b10 has no defined meaning here. The stimulus drives only the machine, supervisor and user encodings, changes inputs away from the clock edge, and never holds an address that maps to two registers. Lower-mode stimulus is repeated over every value of the virtualization flag, so each source of the effective enable is exercised.

// File: rtl/sstk_enable_ctl.sv
module sstk_enable_ctl #(
  parameter int          XLEN    = 64,
  parameter int          SSE_BIT = 3,
  parameter logic [11:0] A_MENV  = 12'h30A,
  parameter logic [11:0] A_HENV  = 12'h60A,
  parameter logic [11:0] A_SENV  = 12'h10A,
  parameter logic [11:0] A_SSP   = 12'h011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [XLEN/8-1:0] csr_wstrb,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic [2:0]        pte_perm,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              eff_en,
  output logic              illegal,
  output logic              pte_rsvd,
  output logic              mop_fallback
);
  localparam int         NB     = XLEN / 8;
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_S = 2'b01;

  logic [XLEN-1:0] menv_q, henv_q, senv_q, ssp_q;
  logic [XLEN-1:0] menv_d, henv_d, senv_d, ssp_d;
  logic [XLEN-1:0] bmask;

  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign bmask[8*i +: 8] = {8{csr_wstrb[i]}};
  end

  wire wr      = csr_req & csr_we;
  wire hit_m   = csr_req & (csr_addr == A_MENV);
  wire hit_h   = csr_req & (csr_addr == A_HENV);
  wire hit_s   = csr_req & (csr_addr == A_SENV);
  wire hit_ssp = csr_req & (csr_addr == A_SSP);
  wire m_on    = menv_q[SSE_BIT];
  wire is_m    = (priv == PRIV_M);

  always_comb begin
    if (is_m)               eff_en = 1'b1;
    else if (priv == PRIV_S) eff_en = virt ? henv_q[SSE_BIT] : m_on;
    else                    eff_en = senv_q[SSE_BIT];
  end

  wire ssp_ok = is_m | eff_en;
  assign illegal      = hit_ssp & ~ssp_ok;
  assign mop_fallback = ~is_m & ~m_on;
  assign pte_rsvd     = ~m_on & (pte_perm == 3'b010);

  always_comb begin
    menv_d = (wr & hit_m) ? ((menv_q & ~bmask) | (csr_wdata & bmask)) : menv_q;
    henv_d = (wr & hit_h) ? ((henv_q & ~bmask) | (csr_wdata & bmask)) : henv_q;
    senv_d = (wr & hit_s) ? ((senv_q & ~bmask) | (csr_wdata & bmask)) : senv_q;
    ssp_d  = (wr & hit_ssp & ssp_ok) ? ((ssp_q & ~bmask) | (csr_wdata & bmask)) : ssp_q;
    henv_d[SSE_BIT] = henv_d[SSE_BIT] & menv_d[SSE_BIT];
    senv_d[SSE_BIT] = senv_d[SSE_BIT] & menv_d[SSE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menv_q <= '0;
      henv_q <= '0;
      senv_q <= '0;
      ssp_q  <= '0;
    end else begin
      menv_q <= menv_d;
      henv_q <= henv_d;
      senv_q <= senv_d;
      ssp_q  <= ssp_d;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (hit_m)                 csr_rdata = menv_q;
    else if (hit_h)            csr_rdata = henv_q;
    else if (hit_s)            csr_rdata = senv_q;
    else if (hit_ssp & ssp_ok) csr_rdata = ssp_q;
  end
endmodule

module sstk_enable_ctl_chk #(
  parameter int          XLEN    = 64,
  parameter int          SSE_BIT = 3,
  parameter logic [11:0] A_MENV  = 12'h30A,
  parameter logic [11:0] A_HENV  = 12'h60A,
  parameter logic [11:0] A_SSP   = 12'h011
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_req,
  input logic              csr_we,
  input logic [11:0]       csr_addr,
  input logic [XLEN-1:0]   csr_wdata,
  input logic [XLEN/8-1:0] csr_wstrb,
  input logic [1:0]        priv,
  input logic              virt,
  input logic [2:0]        pte_perm,
  input logic [XLEN-1:0]   csr_rdata,
  input logic              eff_en,
  input logic              illegal,
  input logic              pte_rsvd,
  input logic              mop_fallback,
  input logic              menv_bit
);
  assert_mmode_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    priv == 2'b11 |-> eff_en);

  assert_s_follows_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'b01 && !virt) |-> (eff_en == menv_bit));

  assert_lower_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_addr == A_HENV && !menv_bit) |-> !csr_rdata[SSE_BIT]);

  assert_m_write_next_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_we && csr_addr == A_MENV && csr_wstrb[SSE_BIT/8])
      |=> (menv_bit == $past(csr_wdata[SSE_BIT])));

  assert_ssp_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_addr == A_SSP && priv != 2'b11 && !eff_en) |-> (illegal && csr_rdata == '0));

  assert_ssp_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == 2'b11 || eff_en) |-> !illegal);

  assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv != 2'b11 && !menv_bit) |-> mop_fallback);

  assert_pte_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!menv_bit && pte_perm == 3'b010) |-> pte_rsvd);

  assert_pte_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    menv_bit |-> !pte_rsvd);
endmodule

bind sstk_enable_ctl sstk_enable_ctl_chk #(
  .XLEN(XLEN), .SSE_BIT(SSE_BIT), .A_MENV(A_MENV), .A_HENV(A_HENV), .A_SSP(A_SSP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
  .csr_wdata(csr_wdata), .csr_wstrb(csr_wstrb), .priv(priv), .virt(virt),
  .pte_perm(pte_perm), .csr_rdata(csr_rdata), .eff_en(eff_en), .illegal(illegal),
  .pte_rsvd(pte_rsvd), .mop_fallback(mop_fallback), .menv_bit(menv_q[SSE_BIT])
);

// File: tb/sstk_enable_ctl_tb.sv
module sstk_enable_ctl_tb;
  localparam int XLEN = 64;
  localparam int NB = XLEN / 8;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] AM = 12'h30A, AH = 12'h60A, AS = 12'h10A, AP = 12'h011;

  logic clk = 0, rst_n = 0;
  logic csr_req = 0, csr_we = 0, virt = 0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [NB-1:0] csr_wstrb = '0;
  logic [1:0] priv = 2'b11;
  logic [2:0] pte_perm = '0;
  logic [XLEN-1:0] csr_rdata;
  logic eff_en, illegal, pte_rsvd, mop_fallback;

  int n_tests = 0, n_fail = 0;
  logic [XLEN-1:0] m_m = 0, m_h = 0, m_s = 0, m_p = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sstk_enable_ctl #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_wstrb(csr_wstrb), .priv(priv), .virt(virt),
    .pte_perm(pte_perm), .csr_rdata(csr_rdata), .eff_en(eff_en), .illegal(illegal),
    .pte_rsvd(pte_rsvd), .mop_fallback(mop_fallback));

  task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic model_eff();
    if (priv == 2'b11) return 1'b1;
    if (priv == 2'b01) return virt ? m_h[3] : m_m[3];
    return m_s[3];
  endfunction

  function automatic logic [XLEN-1:0] merge(logic [XLEN-1:0] old);
    logic [XLEN-1:0] r = old;
    for (int i = 0; i < NB; i++)
      if (csr_wstrb[i]) r[8*i +: 8] = csr_wdata[8*i +: 8];
    return r;
  endfunction

  // one cycle: drive, compare every output against the model, then advance the model
  task automatic step(bit req, bit we, logic [11:0] a, logic [XLEN-1:0] d, logic [NB-1:0] st,
                      logic [1:0] p, bit v, logic [2:0] pp, string rtag);
    logic ok, e;
    logic [XLEN-1:0] rd;
    @(negedge clk);
    csr_req = req; csr_we = we; csr_addr = a; csr_wdata = d; csr_wstrb = st;
    priv = p; virt = v; pte_perm = pp;
    #1;
    e = model_eff();
    ok = (p == 2'b11) || e;
    rd = '0;
    if (req) begin
      if (a == AM) rd = m_m;
      else if (a == AH) rd = m_h;
      else if (a == AS) rd = m_s;
      else if (a == AP && ok) rd = m_p;
    end
    chk(p == 2'b11 ? "R2" : "R3", "eff_en", XLEN'(eff_en), XLEN'(e));
    chk(rtag, "csr_rdata", csr_rdata, rd);
    chk(ok ? "R8" : "R7", "illegal", XLEN'(illegal), XLEN'(req && a == AP && !ok));
    chk("R9", "mop_fallback", XLEN'(mop_fallback), XLEN'(p != 2'b11 && !m_m[3]));
    chk("R10", "pte_rsvd", XLEN'(pte_rsvd), XLEN'(!m_m[3] && pp == 3'b010));
    @(posedge clk);
    if (req && we) begin
      if (a == AM) begin
        m_m = merge(m_m);
        if (!m_m[3]) begin m_h[3] = 0; m_s[3] = 0; end
      end else if (a == AH) begin
        m_h = merge(m_h); m_h[3] = m_h[3] & m_m[3];
      end else if (a == AS) begin
        m_s = merge(m_s); m_s[3] = m_s[3] & m_m[3];
      end else if (a == AP && ok) m_p = merge(m_p);
    end
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] p, bit v, string t);
    step(1, 0, a, '0, '0, p, v, 3'b010, t);
  endtask

  task automatic wr(logic [11:0] a, logic [XLEN-1:0] d, logic [NB-1:0] st, logic [1:0] p, bit v, string t);
    step(1, 1, a, d, st, p, v, 3'b000, t);
  endtask

  task automatic sweep(string t);
    for (int p = 0; p < 2; p++)
      for (int v = 0; v < 2; v++)
        for (int q = 0; q < 8; q++)
          step(0, 0, '0, '0, '0, 2'(p), v[0], 3'(q), t);
    step(0, 0, '0, '0, '0, 2'b11, 0, 3'b010, t);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset values
    rd(AM, 2'b11, 0, "R1"); rd(AH, 2'b11, 0, "R1");
    rd(AS, 2'b11, 0, "R1"); rd(AP, 2'b11, 0, "R1");
    sweep("R9");
    // R4: flag writes dropped while machine flag is 0, other bits stored (R6)
    wr(AH, {XLEN{1'b1}}, '1, 2'b11, 0, "R4");
    wr(AS, 64'h0123_4567_89AB_CDEF, '1, 2'b11, 0, "R4");
    rd(AH, 2'b11, 0, "R4"); rd(AS, 2'b11, 0, "R4");
    // R7: shadow-stack pointer blocked below M
    wr(AP, 64'hDEAD_BEEF, '1, 2'b01, 0, "R7");
    rd(AP, 2'b01, 0, "R7"); rd(AP, 2'b00, 1, "R7"); rd(AP, 2'b11, 0, "R7");
    // R6: strobes
    wr(AM, 64'hFFFF_FFFF_FFFF_FF08, 8'h00, 2'b11, 0, "R6");
    rd(AM, 2'b11, 0, "R6");
    wr(AM, 64'hA5A5_0000_0000_0008, 8'hC1, 2'b11, 0, "R6");
    rd(AM, 2'b11, 0, "R6");
    wr(AH, 64'h8, 8'h01, 2'b11, 0, "R3");
    wr(AS, 64'h8, 8'h01, 2'b11, 0, "R3");
    rd(AH, 2'b11, 0, "R3"); rd(AS, 2'b11, 0, "R3");
    sweep("R3");
    // R8: legal pointer access from lower modes
    wr(AP, 64'h1122_3344_5566_7788, '1, 2'b01, 0, "R8");
    rd(AP, 2'b01, 1, "R8");
    wr(AP, 64'h0000_0000_0000_00FF, 8'h01, 2'b00, 1, "R8");
    rd(AP, 2'b00, 0, "R8");
    wr(AH, 64'h0, 8'h01, 2'b11, 0, "R3");
    sweep("R3");
    wr(AP, 64'h0, '1, 2'b01, 1, "R7");
    rd(AP, 2'b11, 0, "R8");
    // R5: clearing the machine flag wipes lower flags for good
    wr(AH, 64'h8, 8'h01, 2'b11, 0, "R5");
    wr(AM, 64'h0, 8'h01, 2'b11, 0, "R5");
    rd(AH, 2'b11, 0, "R5"); rd(AS, 2'b11, 0, "R5");
    wr(AM, 64'h8, 8'h01, 2'b11, 0, "R5");
    rd(AH, 2'b11, 0, "R5"); rd(AS, 2'b11, 0, "R5");
    sweep("R5");
    rd(AM, 2'b11, 0, "R6");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule